// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-up to a usable state. When reset is released, with the clock assumed stable, it holds the command bus at NOP for a power-up wait whose length is given in cycles. It then closes every bank with one precharge-all command and issues two auto-refresh commands. Last, it writes the mode word, built from the burst, latency and write-mode inputs. Every gap between two commands is filled with NOPs. A ready flag rises once the gap after the mode load has run out. A memory controller holds off its own traffic until that flag is high.

The control is a single state machine. From reset it walks through these states in order: `ST_POWER_WAIT`, `ST_PRECHARGE`, `ST_GAP_RP`, `ST_REFRESH_A`, `ST_GAP_RFC_A`, `ST_REFRESH_B`, `ST_GAP_RFC_B`, `ST_LOAD_MODE`, `ST_GAP_MRD`, `ST_READY`.

- A wait state moves on when the shared down-counter reads zero. These are the power-up wait and the three gap kinds: precharge to refresh, refresh to refresh or mode load, and mode load to ready.
- A command state always lasts one cycle. It loads the counter for the gap that follows.
- `ST_READY` is terminal. Only reset leaves it.

The gap parameters count cycles from one command to the next and must be at least 2. The power-up wait must be at least 1.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, the command output is NOP, the address and bank outputs are zero and ready is low. Commands are coded as {row strobe, column strobe, write enable}, active low: NOP = 3'b111, PRECHARGE = 3'b010, REFRESH = 3'b001, LOAD_MODE = 3'b000.
- R2: After reset is released, the command is NOP for exactly WAIT_CYC clock edges. The precharge appears after the WAIT_CYC-th rising edge.
- R3: The precharge-all command lasts one cycle. It carries address bit 10 high, all other address bits low, and bank zero.
- R4: The first REFRESH is issued exactly T_RP_CYC cycles after the precharge, with NOP in every cycle between.
- R5: The second REFRESH is issued exactly T_RFC_CYC cycles after the first, with NOP between.
- R6: LOAD_MODE is issued exactly T_RFC_CYC cycles after the second refresh, with bank zero. The address holds these fields:
  - burst length in bits 2:0
  - burst type in bit 3
  - CAS latency in bits 6:4
  - operating mode in bits 8:7
  - write burst mode in bit 9
  - bits 12:10 always low.
- R7: Ready rises exactly T_MRD_CYC cycles after LOAD_MODE. It then stays high with the command held at NOP and the address at zero.
- R8: Each non-NOP command lasts a single cycle. One sequence issues exactly one precharge, two refreshes and one mode load.
- R9: Reset asserted in the middle of the sequence drops ready and the command to their reset values. After release, the whole sequence restarts from the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst length code for the mode word |
| burst_seq_i | input | 1 | Burst type (0 sequential, 1 interleaved) |
| cas_lat_i | input | 3 | CAS latency code |
| op_mode_i | input | 2 | Operating mode code |
| wr_single_i | input | 1 | Write burst mode bit |
| cmd_o | output | 3 | Command {row strobe, column strobe, write enable}, active low |
| addr_o | output | ROW_W | Address bus (13 by default) |
| bank_o | output | BANK_W | Bank address (2 by default) |
| ready_o | output | 1 | Initialization complete |

## Verification
The assertions check local rules on every cycle:
- ready, once high, stays high with NOP on the bus;
- every non-NOP command lasts one cycle;
- the bank output stays zero;
- the precharge address has only bit 10 set;
- the reserved bits of the mode word stay low.

The exact spacing between commands can only be shown by the bench's scenarios. So can the order of the four commands, the field placement for several mode values, and the full restart after a reset in mid-sequence. The bench compares every cycle against a timeline it derives from the parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_LOAD_MODE = 3'b000,
        CMD_REFRESH   = 3'b001,
        CMD_PRECHARGE = 3'b010,
        CMD_NOP       = 3'b111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ST_POWER_WAIT,
        ST_PRECHARGE,
        ST_GAP_RP,
        ST_REFRESH_A,
        ST_GAP_RFC_A,
        ST_REFRESH_B,
        ST_GAP_RFC_B,
        ST_LOAD_MODE,
        ST_GAP_MRD,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic       wr_single;
        logic [1:0] op_mode;
        logic [2:0] cas_lat;
        logic       burst_seq;
        logic [2:0] burst_len;
    } mode_fields_t;

    localparam int unsigned ALL_BANK_BIT = 10;
    localparam int unsigned MODE_USED_W  = 10;

endpackage

// File: rtl/init_gap_timer.sv
module init_gap_timer #(
    parameter int unsigned     CNT_W     = 16,
    parameter logic [CNT_W-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/init_mode_word.sv
module init_mode_word
    import sdram_init_pkg::*;
#(
    parameter int unsigned ROW_W = 13
) (
    input  mode_fields_t     fields_i,
    output logic [ROW_W-1:0] word_o
);

    always_comb begin
        word_o = '0;
        word_o[MODE_USED_W-1:0] = fields_i;
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned WAIT_CYC  = 13300,
    parameter int unsigned T_RP_CYC  = 3,
    parameter int unsigned T_RFC_CYC = 10,
    parameter int unsigned T_MRD_CYC = 2,
    parameter int unsigned ROW_W     = 13,
    parameter int unsigned BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        burst_len_i,
    input  logic              burst_seq_i,
    input  logic [2:0]        cas_lat_i,
    input  logic [1:0]        op_mode_i,
    input  logic              wr_single_i,
    output logic [2:0]        cmd_o,
    output logic [ROW_W-1:0]  addr_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              ready_o
);

    localparam int unsigned MAX_A   = (WAIT_CYC > T_RP_CYC) ? WAIT_CYC : T_RP_CYC;
    localparam int unsigned MAX_B   = (T_RFC_CYC > T_MRD_CYC) ? T_RFC_CYC : T_MRD_CYC;
    localparam int unsigned MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W   = $clog2(MAX_ALL + 1) + 1;

    localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] RP_LOAD   = CNT_W'(T_RP_CYC - 2);
    localparam logic [CNT_W-1:0] RFC_LOAD  = CNT_W'(T_RFC_CYC - 2);
    localparam logic [CNT_W-1:0] MRD_LOAD  = CNT_W'(T_MRD_CYC - 2);

    init_state_e      state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    mode_fields_t     fields;
    logic [ROW_W-1:0] mode_word;

    init_gap_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (WAIT_LOAD)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    assign fields = '{wr_single: wr_single_i, op_mode: op_mode_i, cas_lat: cas_lat_i,
                      burst_seq: burst_seq_i, burst_len: burst_len_i};

    init_mode_word #(.ROW_W(ROW_W)) u_mode (
        .fields_i (fields),
        .word_o   (mode_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_POWER_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_POWER_WAIT: if (tmr_zero) state_d = ST_PRECHARGE;
            ST_PRECHARGE: begin
                state_d  = ST_GAP_RP;
                tmr_load = 1'b1;
                tmr_val  = RP_LOAD;
            end
            ST_GAP_RP:    if (tmr_zero) state_d = ST_REFRESH_A;
            ST_REFRESH_A: begin
                state_d  = ST_GAP_RFC_A;
                tmr_load = 1'b1;
                tmr_val  = RFC_LOAD;
            end
            ST_GAP_RFC_A: if (tmr_zero) state_d = ST_REFRESH_B;
            ST_REFRESH_B: begin
                state_d  = ST_GAP_RFC_B;
                tmr_load = 1'b1;
                tmr_val  = RFC_LOAD;
            end
            ST_GAP_RFC_B: if (tmr_zero) state_d = ST_LOAD_MODE;
            ST_LOAD_MODE: begin
                state_d  = ST_GAP_MRD;
                tmr_load = 1'b1;
                tmr_val  = MRD_LOAD;
            end
            ST_GAP_MRD:   if (tmr_zero) state_d = ST_READY;
            ST_READY:     state_d = ST_READY;
            default:      state_d = ST_POWER_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_o   = CMD_NOP;
        addr_o  = '0;
        bank_o  = '0;
        ready_o = 1'b0;
        unique case (state_q)
            ST_PRECHARGE: begin
                cmd_o                = CMD_PRECHARGE;
                addr_o[ALL_BANK_BIT] = 1'b1;
            end
            ST_REFRESH_A, ST_REFRESH_B: cmd_o = CMD_REFRESH;
            ST_LOAD_MODE: begin
                cmd_o  = CMD_LOAD_MODE;
                addr_o = mode_word;
            end
            ST_READY: ready_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd_o,
    input logic [ROW_W-1:0]  addr_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              ready_o
);

    localparam logic [2:0] NOP_C = 3'b111;
    localparam logic [2:0] PRE_C = 3'b010;
    localparam logic [2:0] LMR_C = 3'b000;

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (cmd_o == NOP_C && !ready_o && addr_o == '0);
        end
    end

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

    // R7
    ready_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cmd_o == NOP_C && addr_o == '0));

    // R8
    single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != NOP_C) |=> (cmd_o == NOP_C));

    // R3
    precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == PRE_C) |-> ($countones(addr_o) == 1 && addr_o[10]));

    // R6
    mode_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == LMR_C) |-> (addr_o[ROW_W-1:10] == '0));

    // R6
    bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_o == '0);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_o   (cmd_o),
    .addr_o  (addr_o),
    .bank_o  (bank_o),
    .ready_o (ready_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

    localparam int WAIT  = 20;
    localparam int TRP   = 3;
    localparam int TRFC  = 5;
    localparam int TMRD  = 2;
    localparam int E_PRE = WAIT;
    localparam int E_RF1 = E_PRE + TRP;
    localparam int E_RF2 = E_RF1 + TRFC;
    localparam int E_LMR = E_RF2 + TRFC;
    localparam int E_RDY = E_LMR + TMRD;

    localparam logic [2:0] NOP_C = 3'b111;
    localparam logic [2:0] PRE_C = 3'b010;
    localparam logic [2:0] REF_C = 3'b001;
    localparam logic [2:0] LMR_C = 3'b000;

    // {wr_single, op_mode, cas_lat, burst_seq, burst_len} and the expected address
    localparam int NVEC = 4;
    localparam logic [9:0]  MODE_IN  [NVEC] = '{10'b0_00_011_0_011, 10'b1_00_010_1_111,
                                                10'b1_11_010_1_010, 10'b0_00_000_0_000};
    localparam logic [12:0] MODE_EXP [NVEC] = '{13'h033, 13'h22F, 13'h3AA, 13'h000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  burst_len;
    logic        burst_seq;
    logic [2:0]  cas_lat;
    logic [1:0]  op_mode;
    logic        wr_single;
    logic [2:0]  cmd;
    logic [12:0] addr;
    logic [1:0]  bank;
    logic        ready;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .WAIT_CYC (WAIT), .T_RP_CYC (TRP), .T_RFC_CYC (TRFC), .T_MRD_CYC (TMRD),
        .ROW_W (13), .BANK_W (2)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .burst_len_i (burst_len), .burst_seq_i (burst_seq),
        .cas_lat_i (cas_lat), .op_mode_i (op_mode), .wr_single_i (wr_single),
        .cmd_o (cmd), .addr_o (addr), .bank_o (bank), .ready_o (ready)
    );

    task automatic check(input string req, input logic [2:0] ec, input logic [12:0] ea,
                         input logic er, input int e);
        checks++;
        if (cmd !== ec || addr !== ea || bank !== 2'b00 || ready !== er) begin
            fails++;
            $display("FAIL %s edge %0d: cmd=%b addr=%h bank=%b ready=%b expected cmd=%b addr=%h bank=00 ready=%b",
                     req, e, cmd, addr, bank, ready, ec, ea, er);
        end
    endtask

    function automatic string req_of(input int e);
        if (e < E_PRE)  return "R2";
        if (e == E_PRE) return "R3";
        if (e <= E_RF1) return "R4";
        if (e <= E_RF2) return "R5";
        if (e <= E_LMR) return "R6";
        if (e < E_RDY)  return "R8";
        return "R7";
    endfunction

    // Reset, then follow the timeline up to edge stop_at (or the full run if stop_at < 0)
    task automatic run_seq(input int idx, input int stop_at);
        {wr_single, op_mode, cas_lat, burst_seq, burst_len} = MODE_IN[idx];
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", NOP_C, 13'h0, 1'b0, -1);
        rst_n = 1'b1;
        check("R2", NOP_C, 13'h0, 1'b0, 0);
        for (int e = 1; e <= E_RDY + 4; e++) begin
            logic [2:0]  ec;
            logic [12:0] ea;
            if (stop_at >= 0 && e > stop_at) break;
            @(posedge clk);
            @(negedge clk);
            ec = NOP_C;
            ea = 13'h0;
            if (e == E_PRE) begin ec = PRE_C; ea = 13'h400; end
            else if (e == E_RF1 || e == E_RF2) ec = REF_C;
            else if (e == E_LMR) begin ec = LMR_C; ea = MODE_EXP[idx]; end
            check(req_of(e), ec, ea, (e >= E_RDY), e);
        end
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        {wr_single, op_mode, cas_lat, burst_seq, burst_len} = '0;
        // Table-driven runs: the full sequence for each mode value (R2-R8)
        for (int i = 0; i < NVEC; i++) begin
            run_seq(i, -1);
        end
        // R9: reset in the precharge-to-refresh gap, then a full restart
        run_seq(1, E_PRE + 1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", NOP_C, 13'h0, 1'b0, -1);
        run_seq(2, -1);
        // R9: reset while ready is high
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", NOP_C, 13'h0, 1'b0, -1);
        // R2: the boundary edge just before the precharge is still NOP
        run_seq(0, E_PRE - 1);
        check("R2", NOP_C, 13'h0, 1'b0, E_PRE - 1);
        report();
    end

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
    end

endmodule